// File: doc/BRIEF.md
# Physical Register Wakeup Scoreboard

This block tracks, for every physical register of an out-of-order core, whether its value has been produced, and it tells waiting issue-queue slots when their operands arrive. The register index space is the integer physical register count plus the floating-point physical register count. Each index has one ready bit. Each issue-queue slot holds a small set of source-wait records, and each record is a register tag.

At dispatch, the issue stage names the slot being filled, the optional destination of the instruction, and the sources that rename reported as not yet ready. The destination's ready bit is cleared. Each reported source is checked again against the scoreboard. The check also sees completions that arrive in the same cycle. A source found ready leaves no wait record behind. Up to two completion ports broadcast result tags each cycle. A broadcast sets the register's ready bit and clears every matching wait record.

A slot whose last wait record is cleared raises its bit in a one-cycle wake vector. The same bit is raised for a slot that was dispatched with no waits left. A squash mask discards the wait records of the named slots. Tags at or above the physical register count are never tracked.

Top module: `preg_wakeup_sb`

## Requirements
- R1: After reset every bit of `reg_ready` and every bit of `wake_vec` is 0.
- R2: A dispatch with `disp_dst_valid` and an in-range destination tag clears that register's `reg_ready` bit on the next clock edge.
- R3: Each completion port whose `cmp_valid` bit is set and whose tag is in range sets that register's `reg_ready` bit on the next clock edge. Both ports act in the same cycle. Port c uses bits [c*7 +: 7] of `cmp_tag`.
- R4: A dispatched source, flagged in `disp_src_valid[i]` with its tag in `disp_src_tag[i*7 +: 7]`, records no wait if its register is already ready or is completed in the same cycle. A slot dispatched with no waits raises `wake_vec[slot]` on the next edge.
- R5: A slot that holds waits keeps `wake_vec[slot]` at 0 until the completion that clears its last wait. It raises `wake_vec[slot]` on the edge that follows that completion.
- R6: If a dispatch destination and a completion name the same register in one cycle, the register ends not ready, because the new producer wins.
- R7: Tags at or above NUM_PREGS (64 by default) are ignored. Such a source records no wait. Such a destination or completion leaves `reg_ready` unchanged.
- R8: Setting `squash_mask[slot]` discards that slot's waits without a wake. A later completion of a discarded tag does not wake the slot.
- R9: Every `wake_vec` pulse lasts exactly one cycle, unless the slot is dispatched again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| disp_valid | input | 1 | Dispatch into slot `disp_slot` this cycle |
| disp_slot | input | SLOT_W (3) | Issue-queue slot being filled |
| disp_dst_valid | input | 1 | Dispatched instruction writes `disp_dst_tag` |
| disp_dst_tag | input | TAG_W (7) | Destination physical register tag |
| disp_src_valid | input | SRCS (2) | Source i was reported not ready by rename |
| disp_src_tag | input | SRCS*TAG_W (14) | Source tags, source i at [i*TAG_W +: TAG_W] |
| cmp_valid | input | CMP_PORTS (2) | Completion broadcast valid, one bit per port |
| cmp_tag | input | CMP_PORTS*TAG_W (14) | Completed destination tags, port c at [c*TAG_W +: TAG_W] |
| squash_mask | input | SLOTS (8) | Slots whose waits are discarded |
| reg_ready | output | NUM_PREGS (64) | Scoreboard ready bits |
| wake_vec | output | SLOTS (8) | One-cycle pulse per slot that became fully ready |

## Verification
The assertions assume that the issue stage never dispatches into a slot and squashes that same slot in one cycle. Where the two do meet, dispatch is taken to win, and the checks on squash silence and on pulse length exclude the dispatched slot. The property on completion setting a bit holds only when no dispatch destination names the same register in that cycle, so that case is carved out of it. The directed stimulus drives each scenario at the falling edge on otherwise idle inputs. This keeps any two events that touch one register or one slot in a single cycle confined to the tests that target that collision.

// File: rtl/sb_pkg.sv
`timescale 1ns/1ps
package sb_pkg;
  // true when a tag addresses a tracked physical register
  function automatic logic tag_below(input logic [15:0] tag, input int unsigned bound);
    return (32'(tag) < bound);
  endfunction
endpackage

// File: rtl/sb_rst_sync.sv
`timescale 1ns/1ps
module sb_rst_sync (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_sync = sync_q;
endmodule

// File: rtl/sb_tag_decode.sv
`timescale 1ns/1ps
module sb_tag_decode #(
  parameter int NUM_PREGS = 64,
  parameter int TAG_W     = 7
) (
  input  logic                 en,
  input  logic [TAG_W-1:0]     tag,
  output logic [NUM_PREGS-1:0] onehot
);
  // tags outside the range match no line, so they fall away here
  for (genvar r = 0; r < NUM_PREGS; r++) begin : g_line
    assign onehot[r] = en && (tag == TAG_W'(r));
  end
endmodule

// File: rtl/sb_ready_array.sv
`timescale 1ns/1ps
module sb_ready_array #(
  parameter int NUM_PREGS = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PREGS-1:0] set_vec,
  input  logic [NUM_PREGS-1:0] clr_vec,
  output logic [NUM_PREGS-1:0] ready_q,
  output logic [NUM_PREGS-1:0] ready_now
);
  logic [NUM_PREGS-1:0] ready_d;
  logic                 upd_en;

  always_comb begin
    // completion first, then the new producer's clear
    ready_now = ready_q | set_vec;
    ready_d   = ready_now & ~clr_vec;
    upd_en    = (|set_vec) | (|clr_vec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ready_q <= '0;
    else if (upd_en) ready_q <= ready_d;
  end
endmodule

// File: rtl/sb_wait_slot.sv
`timescale 1ns/1ps
module sb_wait_slot #(
  parameter int TAG_W     = 7,
  parameter int SRCS      = 2,
  parameter int CMP_PORTS = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       disp_en,
  input  logic [SRCS-1:0]            disp_wait,
  input  logic [SRCS*TAG_W-1:0]      disp_tag,
  input  logic                       squash,
  input  logic [CMP_PORTS-1:0]       cmp_valid,
  input  logic [CMP_PORTS*TAG_W-1:0] cmp_tag,
  output logic                       wake_pulse
);
  logic [SRCS-1:0]            wait_q, wait_d, keep;
  logic [SRCS-1:0][TAG_W-1:0] tag_q;
  logic [SRCS-1:0]            hit;
  logic                       wake_d;

  always_comb begin
    for (int i = 0; i < SRCS; i++) begin
      hit[i] = 1'b0;
      for (int c = 0; c < CMP_PORTS; c++) begin
        if (cmp_valid[c] && (cmp_tag[c*TAG_W +: TAG_W] == tag_q[i])) hit[i] = 1'b1;
      end
    end
    keep = wait_q & ~hit;
    if (disp_en) begin
      wait_d = disp_wait;
      wake_d = ~(|disp_wait);
    end else if (squash) begin
      wait_d = '0;
      wake_d = 1'b0;
    end else begin
      wait_d = keep;
      wake_d = (|wait_q) & ~(|keep);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q     <= '0;
      wake_pulse <= 1'b0;
    end else begin
      wait_q     <= wait_d;
      wake_pulse <= wake_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tag_q <= '0;
    else if (disp_en) tag_q <= disp_tag;
  end
endmodule

// File: rtl/preg_wakeup_sb.sv
`timescale 1ns/1ps
module preg_wakeup_sb
  import sb_pkg::*;
#(
  parameter int INT_PREGS = 32,
  parameter int FP_PREGS  = 32,
  parameter int SLOTS     = 8,
  parameter int SRCS      = 2,
  parameter int CMP_PORTS = 2,
  localparam int NUM_PREGS = INT_PREGS + FP_PREGS,
  localparam int IDX_W     = $clog2(NUM_PREGS),
  localparam int TAG_W     = IDX_W + 1,
  localparam int SLOT_W    = $clog2(SLOTS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       disp_valid,
  input  logic [SLOT_W-1:0]          disp_slot,
  input  logic                       disp_dst_valid,
  input  logic [TAG_W-1:0]           disp_dst_tag,
  input  logic [SRCS-1:0]            disp_src_valid,
  input  logic [SRCS*TAG_W-1:0]      disp_src_tag,
  input  logic [CMP_PORTS-1:0]       cmp_valid,
  input  logic [CMP_PORTS*TAG_W-1:0] cmp_tag,
  input  logic [SLOTS-1:0]           squash_mask,
  output logic [NUM_PREGS-1:0]       reg_ready,
  output logic [SLOTS-1:0]           wake_vec
);
  logic rst_sync_n;

  sb_rst_sync u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_sync_n)
  );

  logic [CMP_PORTS-1:0][NUM_PREGS-1:0] cmp_dec;
  logic [NUM_PREGS-1:0]                cmp_hit;
  logic [NUM_PREGS-1:0]                dst_hit;
  logic [NUM_PREGS-1:0]                ready_now;
  logic [SRCS-1:0]                     disp_wait;

  for (genvar c = 0; c < CMP_PORTS; c++) begin : g_cmp
    sb_tag_decode #(.NUM_PREGS(NUM_PREGS), .TAG_W(TAG_W)) u_dec (
      .en     (cmp_valid[c]),
      .tag    (cmp_tag[c*TAG_W +: TAG_W]),
      .onehot (cmp_dec[c])
    );
  end

  always_comb begin
    cmp_hit = '0;
    for (int c = 0; c < CMP_PORTS; c++) cmp_hit = cmp_hit | cmp_dec[c];
  end

  sb_tag_decode #(.NUM_PREGS(NUM_PREGS), .TAG_W(TAG_W)) u_dst_dec (
    .en     (disp_valid && disp_dst_valid),
    .tag    (disp_dst_tag),
    .onehot (dst_hit)
  );

  sb_ready_array #(.NUM_PREGS(NUM_PREGS)) u_ready (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .set_vec   (cmp_hit),
    .clr_vec   (dst_hit),
    .ready_q   (reg_ready),
    .ready_now (ready_now)
  );

  // re-check each reported source, including same-cycle completions
  always_comb begin
    for (int i = 0; i < SRCS; i++) begin
      disp_wait[i] = disp_src_valid[i]
                  && tag_below(16'(disp_src_tag[i*TAG_W +: TAG_W]), NUM_PREGS)
                  && !ready_now[disp_src_tag[i*TAG_W +: IDX_W]];
    end
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    sb_wait_slot #(.TAG_W(TAG_W), .SRCS(SRCS), .CMP_PORTS(CMP_PORTS)) u_slot (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .disp_en    (disp_valid && (disp_slot == SLOT_W'(s))),
      .disp_wait  (disp_wait),
      .disp_tag   (disp_src_tag),
      .squash     (squash_mask[s]),
      .cmp_valid  (cmp_valid),
      .cmp_tag    (cmp_tag),
      .wake_pulse (wake_vec[s])
    );
  end
endmodule

// File: rtl/preg_wakeup_sb_chk.sv
`timescale 1ns/1ps
module preg_wakeup_sb_chk #(
  parameter int NUM_PREGS = 64,
  parameter int TAG_W     = 7,
  parameter int SLOTS     = 8,
  parameter int SLOT_W    = 3,
  parameter int SRCS      = 2,
  parameter int CMP_PORTS = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       disp_valid,
  input logic [SLOT_W-1:0]          disp_slot,
  input logic                       disp_dst_valid,
  input logic [TAG_W-1:0]           disp_dst_tag,
  input logic [SRCS-1:0]            disp_src_valid,
  input logic [CMP_PORTS-1:0]       cmp_valid,
  input logic [CMP_PORTS*TAG_W-1:0] cmp_tag,
  input logic [SLOTS-1:0]           squash_mask,
  input logic [NUM_PREGS-1:0]       reg_ready,
  input logic [SLOTS-1:0]           wake_vec
);
  localparam int IDX_W = TAG_W - 1;

  logic dst_in;
  logic any_cmp_in;

  always_comb begin
    dst_in     = disp_valid && disp_dst_valid && (disp_dst_tag < TAG_W'(NUM_PREGS));
    any_cmp_in = 1'b0;
    for (int c = 0; c < CMP_PORTS; c++) begin
      if (cmp_valid[c] && (cmp_tag[c*TAG_W +: TAG_W] < TAG_W'(NUM_PREGS))) any_cmp_in = 1'b1;
    end
  end

  AST_DST_CLEARS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    dst_in |=> !reg_ready[$past(disp_dst_tag[IDX_W-1:0])]); // R2

  AST_IDLE_KEEPS_SCOREBOARD: assert property (@(posedge clk) disable iff (!rst_n)
    (!dst_in && !any_cmp_in) |=> $stable(reg_ready)); // R7

  for (genvar c = 0; c < CMP_PORTS; c++) begin : g_cmp_chk
    AST_CMP_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_valid[c] && (cmp_tag[c*TAG_W +: TAG_W] < TAG_W'(NUM_PREGS))
       && !(disp_valid && disp_dst_valid && (disp_dst_tag == cmp_tag[c*TAG_W +: TAG_W])))
      |=> reg_ready[$past(cmp_tag[c*TAG_W +: IDX_W])]); // R3
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot_chk
    AST_NOWAIT_DISPATCH_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_valid && (disp_slot == SLOT_W'(s)) && (disp_src_valid == '0)) |=> wake_vec[s]); // R4

    AST_SQUASH_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (squash_mask[s] && !(disp_valid && (disp_slot == SLOT_W'(s)))) |=> !wake_vec[s]); // R8

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_vec[s] && !(disp_valid && (disp_slot == SLOT_W'(s)))) |=> !wake_vec[s]); // R9
  end
endmodule

bind preg_wakeup_sb preg_wakeup_sb_chk #(
  .NUM_PREGS (NUM_PREGS),
  .TAG_W     (TAG_W),
  .SLOTS     (SLOTS),
  .SLOT_W    (SLOT_W),
  .SRCS      (SRCS),
  .CMP_PORTS (CMP_PORTS)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_sync_n),
  .disp_valid     (disp_valid),
  .disp_slot      (disp_slot),
  .disp_dst_valid (disp_dst_valid),
  .disp_dst_tag   (disp_dst_tag),
  .disp_src_valid (disp_src_valid),
  .cmp_valid      (cmp_valid),
  .cmp_tag        (cmp_tag),
  .squash_mask    (squash_mask),
  .reg_ready      (reg_ready),
  .wake_vec       (wake_vec)
);

// File: tb/preg_wakeup_sb_tb.sv
`timescale 1ns/1ps
module preg_wakeup_sb_tb;
  logic        clk;
  logic        rst_n;
  logic        disp_valid;
  logic [2:0]  disp_slot;
  logic        disp_dst_valid;
  logic [6:0]  disp_dst_tag;
  logic [1:0]  disp_src_valid;
  logic [13:0] disp_src_tag;
  logic [1:0]  cmp_valid;
  logic [13:0] cmp_tag;
  logic [7:0]  squash_mask;
  logic [63:0] reg_ready;
  logic [7:0]  wake_vec;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  preg_wakeup_sb u_dut (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_slot(disp_slot),
    .disp_dst_valid(disp_dst_valid), .disp_dst_tag(disp_dst_tag),
    .disp_src_valid(disp_src_valid), .disp_src_tag(disp_src_tag),
    .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .squash_mask(squash_mask),
    .reg_ready(reg_ready), .wake_vec(wake_vec)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    disp_valid = 0; disp_slot = 0; disp_dst_valid = 0; disp_dst_tag = 0;
    disp_src_valid = 0; disp_src_tag = 0; cmp_valid = 0; cmp_tag = 0; squash_mask = 0;
  endtask

  // inputs held for one rising edge, outputs sampled at the next falling edge
  task automatic tick();
    @(negedge clk);
    idle();
  endtask

  task automatic disp(input int slot, input bit dv, input int dst,
                      input logic [1:0] sv, input int s0, input int s1);
    disp_valid = 1; disp_slot = 3'(slot); disp_dst_valid = dv; disp_dst_tag = 7'(dst);
    disp_src_valid = sv; disp_src_tag = {7'(s1), 7'(s0)};
  endtask

  task automatic cmp(input int port, input int tag);
    cmp_valid[port] = 1'b1;
    cmp_tag[port*7 +: 7] = 7'(tag);
  endtask

  task automatic t_reset();
    check("R1 reg_ready", reg_ready, 64'h0);
    check("R1 wake_vec", {56'h0, wake_vec}, 64'h0);
  endtask

  task automatic t_cmp_pair();
    cmp(0, 5); cmp(1, 40); tick();
    check("R3 two ports", reg_ready, (64'h1 << 5) | (64'h1 << 40));
  endtask

  task automatic t_dst_clear();
    disp(0, 1, 5, 2'b00, 0, 0); tick();
    check("R2 dst clear", {63'h0, reg_ready[5]}, 64'h0);
    check("R4 no-wait wake", {56'h0, wake_vec}, 64'h01);
    tick();
    check("R9 pulse ends", {56'h0, wake_vec}, 64'h0);
  endtask

  task automatic t_wait_wake();
    disp(1, 0, 0, 2'b11, 5, 40); tick();
    check("R5 still waiting", {56'h0, wake_vec}, 64'h0);
    tick();
    check("R5 idle waiting", {56'h0, wake_vec}, 64'h0);
    cmp(0, 5); tick();
    check("R5 wake on last", {56'h0, wake_vec}, 64'h02);
    check("R3 bit set", {63'h0, reg_ready[5]}, 64'h1);
    tick();
    check("R9 single pulse", {56'h0, wake_vec}, 64'h0);
  endtask

  task automatic t_two_waits();
    disp(2, 0, 0, 2'b11, 10, 11); tick();
    cmp(0, 10); tick();
    check("R5 one of two", {56'h0, wake_vec}, 64'h0);
    cmp(1, 11); tick();
    check("R5 second of two", {56'h0, wake_vec}, 64'h04);
  endtask

  task automatic t_bypass();
    disp(3, 0, 0, 2'b01, 12, 0); cmp(1, 12); tick();
    check("R4 same-cycle completion", {56'h0, wake_vec}, 64'h08);
    check("R3 bypass bit", {63'h0, reg_ready[12]}, 64'h1);
  endtask

  task automatic t_dst_vs_cmp();
    cmp(0, 20); tick();
    check("R3 preset", {63'h0, reg_ready[20]}, 64'h1);
    disp(6, 1, 20, 2'b00, 0, 0); cmp(0, 20); tick();
    check("R6 producer wins", {63'h0, reg_ready[20]}, 64'h0);
  endtask

  task automatic t_out_of_range();
    logic [63:0] snap;
    snap = reg_ready;
    disp(4, 1, 90, 2'b01, 100, 0); tick();
    check("R7 src ignored", {56'h0, wake_vec}, 64'h10);
    check("R7 dst ignored", reg_ready, snap);
    cmp(0, 100); cmp(1, 127); tick();
    check("R7 cmp ignored", reg_ready, snap);
  endtask

  task automatic t_squash();
    disp(5, 0, 0, 2'b01, 30, 0); tick();
    squash_mask = 8'h20; tick();
    check("R8 squash silent", {56'h0, wake_vec}, 64'h0);
    cmp(0, 30); tick();
    check("R8 no late wake", {56'h0, wake_vec}, 64'h0);
    check("R3 squash bit", {63'h0, reg_ready[30]}, 64'h1);
  endtask

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_cmp_pair();
    t_dst_clear();
    t_wait_wake();
    t_two_waits();
    t_bypass();
    t_dst_vs_cmp();
    t_out_of_range();
    t_squash();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule